// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits behind the write port of a parallel flash controller. It watches the bus writes as they arrive. Each write carries a 12-bit address and an 8-bit data byte. The block recognises multi-write command sequences and turns them into single-clock start pulses. There are four commands: byte program, chip erase, sector erase and boot-sector lock. The array, the program and erase timers, and the pin-level write timing all live in neighbouring blocks.

Every command starts with a two-write unlock prefix. The writes that follow must match an exact address and data pattern. A write that does not fit its step sends the decoder back to idle, and no command is issued.

An identification mode changes what reads return. While it is active, a small read port returns a manufacturer code, a device code, the boot-lock status and a second device code. The device code depends on whether the boot sector sits at the bottom or the top of the array, which is set by a parameter.

While the neighbouring erase engine reports that a chip erase is running, every write is discarded. A discarded write does not change the decoder state.

Top module: `cmd_seq_decoder`

## Requirements
- R1: A command begins with data 0xAA at address 0x555, followed by data 0x55 at address 0xAAA. Only address bits [10:0] are compared, so bit 11 is ignored: 0xD55 and 0x2AA also match.
- R2: After the prefix, data 0xA0 at 0x555 arms byte program. The next write, at any address with any data, raises `prog_start_o`. It also loads that write's address into `tgt_addr_o` and its data into `tgt_data_o`.
- R3: Chip erase is the prefix, 0x80 at 0x555, the prefix again, then 0x10 at 0x555. It raises `chip_erase_o`.
- R4: Sector erase is the same five writes as R3, followed by 0x30 at any address. It raises `sector_erase_o` in the cycle after that sixth write, with `tgt_addr_o` holding the sixth write's address.
- R5: Boot lock is the same five writes as R3, followed by 0x40 at 0x555. It raises `boot_lock_o`.
- R6: The prefix followed by 0x90 at 0x555 sets `id_mode_o`.
- R7: Identification mode is cleared in either of two ways: the prefix followed by 0xF0 at 0x555, or a single 0xF0 written to any address. The only exception is the armed program step of R2, where 0xF0 is program data.
- R8: While `id_mode_o` is 1, `id_data_o` depends on `id_off_i`. Offset 0 returns 0x1F. Offset 1 returns 0x05, or 0x04 when TOP_BOOT=1. Offset 2 returns `boot_locked_i` in bit 0, with the other bits 0. Offset 3 returns 0x0F. While `id_mode_o` is 0, `id_data_o` is 0x00.
- R9: While `erase_busy_i` is 1, a write is dropped. It issues nothing, changes neither the sequence state nor `id_mode_o`, and a partly entered sequence resumes after the busy period.
- R10: A write that does not match the address and data expected at its step returns the decoder to idle without a command.
- R11: Each command pulse is high for exactly one clock. It appears in the cycle after the clock edge that samples the completing write. At most one command pulse is high at a time.
- R12: While `rst_ni` is low, all pulses are 0, `id_mode_o` is 0, `id_data_o` is 0x00 and `tgt_addr_o`/`tgt_data_o` are zero. After reset the decoder is idle, so a partial sequence does not survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | One bus write this cycle |
| wr_addr_i | input | 12 | Write address |
| wr_data_i | input | 8 | Write data |
| erase_busy_i | input | 1 | Chip erase in progress; writes are dropped |
| boot_locked_i | input | 1 | Current boot-sector lock status |
| id_off_i | input | 2 | Identification read offset |
| prog_start_o | output | 1 | Byte program start pulse |
| chip_erase_o | output | 1 | Chip erase start pulse |
| sector_erase_o | output | 1 | Sector erase start pulse |
| boot_lock_o | output | 1 | Boot lock start pulse |
| tgt_addr_o | output | 12 | Captured program or sector address |
| tgt_data_o | output | 8 | Captured program data |
| id_mode_o | output | 1 | Identification mode active |
| id_data_o | output | 8 | Identification read data |

## Verification
A back-to-back stream of writes runs every command form. It includes prefixes that use the 0x2AA alias and an address with bit 11 set, which separates an 11-bit compare from a full 12-bit compare. Both ways of leaving identification mode are tried: the three-write exit and the bare 0xF0. A wrong address with the right data checks that the address is compared as well as the data. Busy writes are placed in the middle of a sequence, so that a decoder which resets its state on a dropped write can be told apart from one that holds its state. A second instance with the top-boot setting confirms the alternative device code.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam logic [7:0] D_UNLK_A = 8'hAA;
  localparam logic [7:0] D_UNLK_B = 8'h55;
  localparam logic [7:0] D_PROG   = 8'hA0;
  localparam logic [7:0] D_ERSE   = 8'h80;
  localparam logic [7:0] D_IDENT  = 8'h90;
  localparam logic [7:0] D_EXIT   = 8'hF0;
  localparam logic [7:0] D_CHIP   = 8'h10;
  localparam logic [7:0] D_SECT   = 8'h30;
  localparam logic [7:0] D_LOCK   = 8'h40;

  localparam logic [7:0] ID_MFR   = 8'h1F;
  localparam logic [7:0] ID_DEV_B = 8'h05;
  localparam logic [7:0] ID_DEV_T = 8'h04;
  localparam logic [7:0] ID_EXT   = 8'h0F;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE1, S_PRE2, S_ARM, S_ER3, S_ER4, S_ER5
  } seq_state_t;

  typedef struct packed {
    logic prog;
    logic chip;
    logic sect;
    logic lock;
  } cmd_vec_t;
endpackage

// File: rtl/cmd_addr_match.sv
module cmd_addr_match #(
  parameter int MATCH_W = 11
) (
  input  logic [MATCH_W-1:0] addr_i,
  output logic               hit_a_o,
  output logic               hit_b_o
);
  localparam logic [MATCH_W-1:0] ADR_A = MATCH_W'(11'h555);
  localparam logic [MATCH_W-1:0] ADR_B = MATCH_W'(11'h2AA);

  assign hit_a_o = (addr_i == ADR_A);
  assign hit_b_o = (addr_i == ADR_B);
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic              hit_a_i,
  input  logic              hit_b_i,
  output cmd_vec_t          cmd_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic              id_mode_o
);
  seq_state_t st_q, st_d;
  cmd_vec_t   cmd_d;
  logic       id_set, id_clr;
  logic       take;
  logic [7:0] d;

  assign take = wr_valid_i & ~busy_i;
  assign d    = wr_data_i[7:0];

  always_comb begin
    st_d   = st_q;
    cmd_d  = '0;
    id_set = 1'b0;
    id_clr = 1'b0;
    if (take) begin
      if (st_q != S_ARM && d == D_EXIT) begin
        // bare exit or prefixed exit; both leave ID mode
        id_clr = 1'b1;
        st_d   = S_IDLE;
      end else begin
        unique case (st_q)
          S_IDLE: st_d = (hit_a_i && d == D_UNLK_A) ? S_PRE1 : S_IDLE;
          S_PRE1: st_d = (hit_b_i && d == D_UNLK_B) ? S_PRE2 : S_IDLE;
          S_PRE2: begin
            st_d = S_IDLE;
            if (hit_a_i) begin
              if (d == D_PROG)       st_d = S_ARM;
              else if (d == D_ERSE)  st_d = S_ER3;
              else if (d == D_IDENT) id_set = 1'b1;
            end
          end
          S_ARM: begin
            cmd_d.prog = 1'b1;
            st_d       = S_IDLE;
          end
          S_ER3: st_d = (hit_a_i && d == D_UNLK_A) ? S_ER4 : S_IDLE;
          S_ER4: st_d = (hit_b_i && d == D_UNLK_B) ? S_ER5 : S_IDLE;
          S_ER5: begin
            st_d = S_IDLE;
            if (d == D_SECT)                cmd_d.sect = 1'b1;
            else if (hit_a_i && d == D_CHIP) cmd_d.chip = 1'b1;
            else if (hit_a_i && d == D_LOCK) cmd_d.lock = 1'b1;
          end
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_IDLE;
      cmd_o      <= '0;
      id_mode_o  <= 1'b0;
      tgt_addr_o <= '0;
      tgt_data_o <= '0;
    end else begin
      st_q  <= st_d;
      cmd_o <= cmd_d;
      if (id_set)      id_mode_o <= 1'b1;
      else if (id_clr) id_mode_o <= 1'b0;
      if (cmd_d.prog || cmd_d.sect) tgt_addr_o <= wr_addr_i;
      if (cmd_d.prog)               tgt_data_o <= wr_data_i;
    end
  end
endmodule

// File: rtl/cmd_id_rom.sv
module cmd_id_rom
  import cmd_dec_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic       id_mode_i,
  input  logic [1:0] off_i,
  input  logic       locked_i,
  output logic [7:0] data_o
);
  logic [7:0] dev_code;

  generate
    if (TOP_BOOT) begin : g_top
      assign dev_code = ID_DEV_T;
    end else begin : g_bot
      assign dev_code = ID_DEV_B;
    end
  endgenerate

  always_comb begin
    data_o = 8'h00;
    if (id_mode_i) begin
      unique case (off_i)
        2'd0: data_o = ID_MFR;
        2'd1: data_o = dev_code;
        2'd2: data_o = {7'b0, locked_i};
        2'd3: data_o = ID_EXT;
        default: data_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              erase_busy_i,
  input  logic              boot_locked_i,
  input  logic [1:0]        id_off_i,
  output logic              prog_start_o,
  output logic              chip_erase_o,
  output logic              sector_erase_o,
  output logic              boot_lock_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0] tgt_data_o,
  output logic              id_mode_o,
  output logic [7:0]        id_data_o
);
  localparam int MATCH_W = ADDR_W - 1;  // top address bit is don't-care

  logic     hit_a, hit_b;
  cmd_vec_t cmd;

  cmd_addr_match #(.MATCH_W(MATCH_W)) u_match (
    .addr_i  (wr_addr_i[MATCH_W-1:0]),
    .hit_a_o (hit_a),
    .hit_b_o (hit_b)
  );

  cmd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .busy_i     (erase_busy_i),
    .hit_a_i    (hit_a),
    .hit_b_i    (hit_b),
    .cmd_o      (cmd),
    .tgt_addr_o (tgt_addr_o),
    .tgt_data_o (tgt_data_o),
    .id_mode_o  (id_mode_o)
  );

  cmd_id_rom #(.TOP_BOOT(TOP_BOOT)) u_rom (
    .id_mode_i (id_mode_o),
    .off_i     (id_off_i),
    .locked_i  (boot_locked_i),
    .data_o    (id_data_o)
  );

  assign prog_start_o   = cmd.prog;
  assign chip_erase_o   = cmd.chip;
  assign sector_erase_o = cmd.sect;
  assign boot_lock_o    = cmd.lock;
endmodule

// File: rtl/cmd_seq_decoder_chk.sv
module cmd_seq_decoder_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              erase_busy_i,
  input logic              prog_start_o,
  input logic              chip_erase_o,
  input logic              sector_erase_o,
  input logic              boot_lock_o,
  input logic [ADDR_W-1:0] tgt_addr_o,
  input logic [DATA_W-1:0] tgt_data_o,
  input logic              id_mode_o,
  input logic [7:0]        id_data_o
);
  logic any_cmd;
  assign any_cmd = prog_start_o | chip_erase_o | sector_erase_o | boot_lock_o;

  p_one_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, chip_erase_o, sector_erase_o, boot_lock_o}));

  p_pulse_width_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cmd |=> !any_cmd);

  p_busy_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_cmd |-> $past(wr_valid_i && !erase_busy_i));

  p_prog_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> (tgt_data_o == $past(wr_data_i) && tgt_addr_o == $past(wr_addr_i)));

  p_chip_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_o |-> $past(wr_data_i) == 8'h10);

  p_sect_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_erase_o |-> (tgt_addr_o == $past(wr_addr_i) && $past(wr_data_i) == 8'h30));

  p_lock_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_lock_o |-> $past(wr_data_i) == 8'h40);

  p_id_enter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_mode_o) |-> ($past(wr_data_i) == 8'h90 && $past(wr_valid_i)));

  p_id_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(id_mode_o) |-> ($past(wr_data_i) == 8'hF0 && $past(wr_valid_i)));

  p_id_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> id_data_o == 8'h00);
endmodule

bind cmd_seq_decoder cmd_seq_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_valid_i     (wr_valid_i),
  .wr_addr_i      (wr_addr_i),
  .wr_data_i      (wr_data_i),
  .erase_busy_i   (erase_busy_i),
  .prog_start_o   (prog_start_o),
  .chip_erase_o   (chip_erase_o),
  .sector_erase_o (sector_erase_o),
  .boot_lock_o    (boot_lock_o),
  .tgt_addr_o     (tgt_addr_o),
  .tgt_data_o     (tgt_data_o),
  .id_mode_o      (id_mode_o),
  .id_data_o      (id_data_o)
);

// File: tb/cmd_seq_decoder_tb.sv
module cmd_seq_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic        locked = 1'b0;
  logic [1:0]  off = '0;
  logic        prog, chip, sect, lock, idm;
  logic [11:0] taddr;
  logic [7:0]  tdata, idd;
  logic        prog_t, chip_t, sect_t, lock_t, idm_t;
  logic [11:0] taddr_t;
  logic [7:0]  tdata_t, idd_t;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmd_seq_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .erase_busy_i(busy), .boot_locked_i(locked), .id_off_i(off),
    .prog_start_o(prog), .chip_erase_o(chip), .sector_erase_o(sect), .boot_lock_o(lock),
    .tgt_addr_o(taddr), .tgt_data_o(tdata), .id_mode_o(idm), .id_data_o(idd)
  );

  cmd_seq_decoder #(.TOP_BOOT(1'b1)) u_dut_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .erase_busy_i(busy), .boot_locked_i(locked), .id_off_i(off),
    .prog_start_o(prog_t), .chip_erase_o(chip_t), .sector_erase_o(sect_t), .boot_lock_o(lock_t),
    .tgt_addr_o(taddr_t), .tgt_data_o(tdata_t), .id_mode_o(idm_t), .id_data_o(idd_t)
  );

  // {addr, data, {prog,chip,sect,lock}, id_mode}
  localparam int NV = 40;
  localparam logic [24:0] VEC [NV] = '{
    {12'h555, 8'hAA, 4'b0000, 1'b0}, {12'h2AA, 8'h55, 4'b0000, 1'b0},
    {12'h555, 8'hA0, 4'b0000, 1'b0}, {12'h123, 8'h5A, 4'b1000, 1'b0},
    {12'h555, 8'hAA, 4'b0000, 1'b0}, {12'hAAA, 8'h55, 4'b0000, 1'b0},
    {12'h555, 8'h80, 4'b0000, 1'b0}, {12'h555, 8'hAA, 4'b0000, 1'b0},
    {12'h2AA, 8'h55, 4'b0000, 1'b0}, {12'h555, 8'h10, 4'b0100, 1'b0},
    {12'h555, 8'hAA, 4'b0000, 1'b0}, {12'hAAA, 8'h55, 4'b0000, 1'b0},
    {12'h555, 8'h80, 4'b0000, 1'b0}, {12'h555, 8'hAA, 4'b0000, 1'b0},
    {12'hAAA, 8'h55, 4'b0000, 1'b0}, {12'h7C4, 8'h30, 4'b0010, 1'b0},
    {12'h555, 8'hAA, 4'b0000, 1'b0}, {12'hAAA, 8'h55, 4'b0000, 1'b0},
    {12'h555, 8'h80, 4'b0000, 1'b0}, {12'h555, 8'hAA, 4'b0000, 1'b0},
    {12'hAAA, 8'h55, 4'b0000, 1'b0}, {12'h555, 8'h40, 4'b0001, 1'b0},
    {12'h555, 8'hAA, 4'b0000, 1'b0}, {12'hAAA, 8'h55, 4'b0000, 1'b0},
    {12'h555, 8'h90, 4'b0000, 1'b1}, {12'h333, 8'hF0, 4'b0000, 1'b0},
    {12'h555, 8'hAA, 4'b0000, 1'b0}, {12'hAAA, 8'h55, 4'b0000, 1'b0},
    {12'h555, 8'h90, 4'b0000, 1'b1}, {12'h555, 8'hAA, 4'b0000, 1'b1},
    {12'hAAA, 8'h55, 4'b0000, 1'b1}, {12'h555, 8'hF0, 4'b0000, 1'b0},
    {12'h555, 8'hAA, 4'b0000, 1'b0}, {12'h555, 8'h55, 4'b0000, 1'b0},
    {12'h555, 8'hA0, 4'b0000, 1'b0}, {12'h123, 8'h00, 4'b0000, 1'b0},
    {12'hD55, 8'hAA, 4'b0000, 1'b0}, {12'hAAA, 8'h55, 4'b0000, 1'b0},
    {12'h555, 8'hA0, 4'b0000, 1'b0}, {12'h0FF, 8'h11, 4'b1000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one write at a negedge; outputs settle after the following posedge
  task automatic wr(input logic [11:0] a, input logic [7:0] dat);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = dat;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 pulses", {prog, chip, sect, lock}, 4'b0);
    chk("R12 id", {idm, idd}, 9'h0);
    chk("R12 tgt", {taddr, tdata}, 20'h0);
    @(negedge clk) rst_n = 1'b1;

    // main vector walk: R1 R2 R3 R4 R5 R6 R7 R10 R11
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][24:13], VEC[i][12:5]);
      chk($sformatf("R11 vec%0d cmd", i), {prog, chip, sect, lock}, VEC[i][4:1]);
      chk($sformatf("R6/R7 vec%0d id", i), idm, VEC[i][0]);
      if (i == 3)  chk("R2 tgt", {taddr, tdata}, {12'h123, 8'h5A});
      if (i == 15) chk("R4 sector addr", taddr, 12'h7C4);
      if (i == 39) chk("R1 bit11 prog tgt", {taddr, tdata}, {12'h0FF, 8'h11});
      if (VEC[i][4:1] != 4'b0) begin
        @(negedge clk);
        chk($sformatf("R11 vec%0d pulse width", i), {prog, chip, sect, lock}, 4'b0);
      end
    end

    // R2: 0xF0 as program data does not count as exit
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'hA0); wr(12'h044, 8'hF0);
    chk("R2 F0 data", {prog, tdata}, {1'b1, 8'hF0});

    // R8 identification reads
    locked = 1'b0;
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'h90);
    off = 2'd0; #1 chk("R8 mfr", idd, 8'h1F);
    off = 2'd1; #1 chk("R8 dev bottom", idd, 8'h05);
    chk("R8 dev top", idd_t, 8'h04);
    off = 2'd2; #1 chk("R8 lock0", idd, 8'h00);
    locked = 1'b1; #1 chk("R8 lock1", idd, 8'h01);
    off = 2'd3; #1 chk("R8 ext", idd, 8'h0F);
    // R12 mid-run reset clears ID mode
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R12 id clear", {idm, idd}, 9'h0);
    @(negedge clk) rst_n = 1'b1;
    // R12 partial sequence dropped by reset
    wr(12'h555, 8'hAA);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    wr(12'hAAA, 8'h55); wr(12'h555, 8'hA0); wr(12'h100, 8'h22);
    chk("R12 no prog after reset", prog, 1'b0);

    // R9 busy: full sequences dropped
    busy = 1'b1;
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'hA0); wr(12'h200, 8'h33);
    chk("R9 busy prog", prog, 1'b0);
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'h90);
    chk("R9 busy id", idm, 1'b0);
    busy = 1'b0;
    // R9 state held across a dropped write
    wr(12'h555, 8'hAA);
    busy = 1'b1; wr(12'hAAA, 8'h55); wr(12'h555, 8'hF0); busy = 1'b0;
    wr(12'hAAA, 8'h55); wr(12'h555, 8'hA0); wr(12'h321, 8'h44);
    chk("R9 resume prog", {prog, taddr, tdata}, {1'b1, 12'h321, 8'h44});

    // R10 wrong sixth-step address for chip erase
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'hAAA, 8'h55); wr(12'h556, 8'h10);
    chk("R10 no chip", {prog, chip, sect, lock}, 4'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule